// File: doc/BRIEF.md
# Coprocessor Block-Transfer Address Sequencer

This block takes a 32-bit coprocessor instruction that moves a group of floating-point registers to or from memory and turns it into a stream of single-word memory transfers. For every word it gives the byte address, the direction (load or store), the destination or source register index and the position of the word within that register. When the group is finished it emits a one-cycle completion pulse together with the updated base-register value and a flag that says whether that value should be written back.

A caller presents the instruction and the current base value with `start_i`. The block takes them only while `accept_o` is high. Transfers come out one per cycle on a valid/ready pair and stall whenever `ready` is low. An instruction with a wrong opcode pattern or a wrong coprocessor number does not start any transfers. It only raises a one-cycle illegal pulse.

The control is a four-state machine:
- **IDLE** is the only state that accepts an instruction. From IDLE a legal start goes to **XFER** and an illegal one goes to **BAD**.
- **XFER** issues the words. On the handshake of the last word it moves to **FIN**.
- **BAD** lasts one cycle and returns to IDLE.
- **FIN** lasts one cycle, carries the completion pulse, and returns to IDLE.

Top module: `fmx_seq`

## Requirements
- R1: A start accepted in IDLE whose bits [27:25] are not 110, or whose bits [11:8] are not 0010, raises `illegal_o` for exactly the next cycle. It issues no transfer and no done pulse, and `accept_o` is high again the cycle after that.
- R2: The register count comes from {bit 22, bit 15}: 01 gives 1 register, 10 gives 2, 11 gives 3 and 00 gives 4. Exactly three words are issued per register.
- R3: Let the modified base be the base plus 4 × bits [7:0] when bit 23 is 1, or the base minus 4 × bits [7:0] when bit 23 is 0. The first word address is this modified base when bit 24 is 1, and the unmodified base when bit 24 is 0.
- R4: Each successive word address is 4 higher than the previous one, across all registers of the operation.
- R5: `xfer_reg_o` starts at bits [14:12] and rises by one, modulo 8, per register. `xfer_word_o` runs 0, 1, 2 within each register.
- R6: `xfer_load_o` equals bit 20 of the instruction (1 = load, 0 = store) for every word.
- R7: The first word is valid the cycle after the start is accepted. While `xfer_valid_o` is high and `xfer_ready_i` is low, the address, register and word outputs hold and valid stays high.
- R8: `done_o` is high for exactly the one cycle after the last word's handshake. `wb_en_o` is high in that cycle exactly when bit 21 is 1, and `wb_val_o` then shows the modified base, for both pre- and post-indexed forms.
- R9: `accept_o` is high only in IDLE. A start raised while an operation is running is ignored: it does not change the transfer stream and raises no illegal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to take `instr_i` and `base_i` |
| instr_i | input | 32 | Block-transfer instruction word |
| base_i | input | 32 | Current base register value |
| accept_o | output | 1 | High when a start will be taken (IDLE) |
| xfer_valid_o | output | 1 | A word transfer is presented |
| xfer_ready_i | input | 1 | Memory side takes the presented word |
| xfer_addr_o | output | 32 | Byte address of the word |
| xfer_load_o | output | 1 | 1 = load from memory, 0 = store |
| xfer_reg_o | output | 3 | Floating-point register index |
| xfer_word_o | output | 2 | Word position within the register (0..2) |
| done_o | output | 1 | One-cycle pulse after the last word |
| wb_en_o | output | 1 | Base write-back requested (with `done_o`) |
| wb_val_o | output | 32 | Offset-modified base value |
| illegal_o | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
The directed cases cover all four register counts, and each one is told apart by the number of words before `done_o`. The cases also cross pre- and post-indexing with up and down offsets, which separates a first address taken from the modified base from one taken from the raw base. Each case pairs these with write-back on or off, so an enable wrongly tied to post-indexing shows up. A start register of 6 with four registers forces the index to wrap past 7. A stalling ready pattern shows that the outputs hold, and a start injected mid-operation shows that it is ignored. An offset of 255 going down tests the widest subtraction. Two rejected encodings, a wrong opcode pattern and a wrong coprocessor number, each produce an illegal pulse with no transfers.

// File: rtl/fmx_pkg.sv
package fmx_pkg;

    // Field widths fixed by the instruction format
    localparam int FMX_INSTR_W = 32;
    localparam int FMX_OFF_W   = 8;
    localparam int FMX_REG_W   = 3;
    localparam int FMX_MAXREG  = 4;
    localparam int FMX_CNT_W   = $clog2(FMX_MAXREG + 1);

    // Decoded instruction fields
    typedef struct packed {
        logic                 opc_ok;
        logic                 cp_ok;
        logic                 pre;
        logic                 up;
        logic                 wback;
        logic                 load;
        logic [FMX_REG_W-1:0] first_reg;
        logic [FMX_CNT_W-1:0] nregs;
        logic [FMX_OFF_W-1:0] offset;
    } fmx_dec_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_BAD  = 2'd2,
        S_FIN  = 2'd3
    } fmx_state_e;

endpackage

// File: rtl/fmx_decode.sv
module fmx_decode
    import fmx_pkg::*;
#(
    parameter int CP_NUM = 2
) (
    input  logic [FMX_INSTR_W-1:0] instr_i,
    output fmx_dec_t               dec_o
);

    logic [1:0] count_sel;
    logic       unused_bits;

    // {Y, X} selects how many registers move
    assign count_sel = {instr_i[22], instr_i[15]};

    // Condition and base register number are consumed elsewhere
    assign unused_bits = ^{instr_i[31:28], instr_i[19:16]};

    always_comb begin
        dec_o.opc_ok    = (instr_i[27:25] == 3'b110);
        dec_o.cp_ok     = (instr_i[11:8] == 4'(CP_NUM));
        dec_o.pre       = instr_i[24];
        dec_o.up        = instr_i[23];
        dec_o.wback     = instr_i[21];
        dec_o.load      = instr_i[20];
        dec_o.first_reg = instr_i[14:12];
        dec_o.offset    = instr_i[7:0];
        unique case (count_sel)
            2'b00:   dec_o.nregs = FMX_CNT_W'(FMX_MAXREG);
            2'b01:   dec_o.nregs = FMX_CNT_W'(1);
            2'b10:   dec_o.nregs = FMX_CNT_W'(2);
            default: dec_o.nregs = FMX_CNT_W'(3);
        endcase
    end

endmodule

// File: rtl/fmx_addr_gen.sv
module fmx_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 8,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              up_i,
    input  logic              pre_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] mod_o
);

    localparam int SHIFT = $clog2(STEP_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] mod_c;
    logic [ADDR_W-1:0] first_c;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mod_q;

    always_comb begin
        scaled  = ADDR_W'(off_i) << SHIFT;
        mod_c   = up_i ? (base_i + scaled) : (base_i - scaled);
        first_c = pre_i ? mod_c : base_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mod_q  <= '0;
        end else if (load_i) begin
            addr_q <= first_c;
            mod_q  <= mod_c;
        end else if (step_i) begin
            addr_q <= addr_q + STEP;
        end
    end

    assign addr_o = addr_q;
    assign mod_o  = mod_q;

endmodule

// File: rtl/fmx_walk.sv
module fmx_walk #(
    parameter int WPR      = 3,
    parameter int MAX_REGS = 4,
    parameter int REG_W    = 3,
    localparam int CNT_W   = $clog2(MAX_REGS + 1),
    localparam int WORD_W  = $clog2(WPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [CNT_W-1:0]  nregs_i,
    input  logic [REG_W-1:0]  first_reg_i,
    output logic [REG_W-1:0]  reg_o,
    output logic [WORD_W-1:0] word_o,
    output logic              last_o
);

    localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WPR - 1);

    logic [REG_W-1:0]  reg_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  left_q;
    logic              word_end;

    assign word_end = (word_q == WORD_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q  <= '0;
            word_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            reg_q  <= first_reg_i;
            word_q <= '0;
            left_q <= nregs_i;
        end else if (step_i) begin
            if (word_end) begin
                word_q <= '0;
                reg_q  <= reg_q + REG_W'(1);
                left_q <= left_q - CNT_W'(1);
            end else begin
                word_q <= word_q + WORD_W'(1);
            end
        end
    end

    assign reg_o  = reg_q;
    assign word_o = word_q;
    assign last_o = word_end && (left_q == CNT_W'(1));

endmodule

// File: rtl/fmx_seq.sv
module fmx_seq
    import fmx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WPR        = 3,
    parameter int STEP_BYTES = 4,
    parameter int CP_NUM     = 2,
    localparam int WORD_W    = $clog2(WPR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [FMX_INSTR_W-1:0] instr_i,
    input  logic [ADDR_W-1:0]      base_i,
    output logic                   accept_o,
    output logic                   xfer_valid_o,
    input  logic                   xfer_ready_i,
    output logic [ADDR_W-1:0]      xfer_addr_o,
    output logic                   xfer_load_o,
    output logic [FMX_REG_W-1:0]   xfer_reg_o,
    output logic [WORD_W-1:0]      xfer_word_o,
    output logic                   done_o,
    output logic                   wb_en_o,
    output logic [ADDR_W-1:0]      wb_val_o,
    output logic                   illegal_o
);

    fmx_dec_t   dec;
    fmx_state_e state_q;
    fmx_state_e state_d;
    logic       take;
    logic       legal;
    logic       load_go;
    logic       step;
    logic       last;
    logic       load_q;
    logic       wback_q;

    fmx_decode #(.CP_NUM(CP_NUM)) u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign take    = (state_q == S_IDLE) && start_i;
    assign legal   = dec.opc_ok && dec.cp_ok;
    assign load_go = take && legal;
    assign step    = (state_q == S_XFER) && xfer_ready_i;

    fmx_addr_gen #(
        .ADDR_W     (ADDR_W),
        .OFF_W      (FMX_OFF_W),
        .STEP_BYTES (STEP_BYTES)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_go),
        .step_i (step),
        .base_i (base_i),
        .off_i  (dec.offset),
        .up_i   (dec.up),
        .pre_i  (dec.pre),
        .addr_o (xfer_addr_o),
        .mod_o  (wb_val_o)
    );

    fmx_walk #(
        .WPR      (WPR),
        .MAX_REGS (FMX_MAXREG),
        .REG_W    (FMX_REG_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_go),
        .step_i      (step),
        .nregs_i     (dec.nregs),
        .first_reg_i (dec.first_reg),
        .reg_o       (xfer_reg_o),
        .word_o      (xfer_word_o),
        .last_o      (last)
    );

    // Per-operation flags captured at accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            wback_q <= 1'b0;
        end else if (load_go) begin
            load_q  <= dec.load;
            wback_q <= dec.wback;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take) state_d = legal ? S_XFER : S_BAD;
            S_XFER: if (step && last) state_d = S_FIN;
            S_BAD:  state_d = S_IDLE;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        accept_o     = 1'b0;
        xfer_valid_o = 1'b0;
        done_o       = 1'b0;
        wb_en_o      = 1'b0;
        illegal_o    = 1'b0;
        unique case (state_q)
            S_IDLE: accept_o = 1'b1;
            S_XFER: xfer_valid_o = 1'b1;
            S_BAD:  illegal_o = 1'b1;
            S_FIN: begin
                done_o  = 1'b1;
                wb_en_o = wback_q;
            end
            default: accept_o = 1'b0;
        endcase
    end

    assign xfer_load_o = load_q;

endmodule

// File: rtl/fmx_seq_chk.sv
module fmx_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int WPR        = 3,
    parameter int STEP_BYTES = 4,
    localparam int WORD_W    = $clog2(WPR)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept_o,
    input logic              xfer_valid_o,
    input logic              xfer_ready_i,
    input logic [ADDR_W-1:0] xfer_addr_o,
    input logic [2:0]        xfer_reg_o,
    input logic [WORD_W-1:0] xfer_word_o,
    input logic              done_o,
    input logic              wb_en_o,
    input logic              illegal_o
);

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!xfer_valid_o && !done_o)) else $error("illegal with activity"); // R1

    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> accept_o) else $error("illegal not one cycle"); // R1

    AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o |-> (xfer_word_o <= WORD_W'(WPR - 1))) else $error("word index out of range"); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i) |=>
            (!xfer_valid_o || xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(STEP_BYTES)))
        else $error("address step wrong"); // R4

    AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && xfer_ready_i && xfer_word_o == WORD_W'(WPR - 1)) |=>
            (!xfer_valid_o || xfer_reg_o == $past(xfer_reg_o) + 3'd1))
        else $error("register step wrong"); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_ready_i) |=>
            (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o) && $stable(xfer_word_o)))
        else $error("stall not held"); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !xfer_valid_o ##1 !done_o) else $error("done not a pulse"); // R8

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o) else $error("write-back outside done"); // R8

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (!xfer_valid_o && !done_o && !illegal_o)) else $error("accept while busy"); // R9

endmodule

bind fmx_seq fmx_seq_chk #(
    .ADDR_W     (ADDR_W),
    .WPR        (WPR),
    .STEP_BYTES (STEP_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_o     (accept_o),
    .xfer_valid_o (xfer_valid_o),
    .xfer_ready_i (xfer_ready_i),
    .xfer_addr_o  (xfer_addr_o),
    .xfer_reg_o   (xfer_reg_o),
    .xfer_word_o  (xfer_word_o),
    .done_o       (done_o),
    .wb_en_o      (wb_en_o),
    .illegal_o    (illegal_o)
);

// File: tb/test_fmx_seq.sv
module test_fmx_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] base_i = '0;
    logic        accept_o;
    logic        xfer_valid_o;
    logic        xfer_ready_i = 1'b0;
    logic [31:0] xfer_addr_o;
    logic        xfer_load_o;
    logic [2:0]  xfer_reg_o;
    logic [1:0]  xfer_word_o;
    logic        done_o;
    logic        wb_en_o;
    logic [31:0] wb_val_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fmx_seq i_fmx_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .instr_i      (instr_i),
        .base_i       (base_i),
        .accept_o     (accept_o),
        .xfer_valid_o (xfer_valid_o),
        .xfer_ready_i (xfer_ready_i),
        .xfer_addr_o  (xfer_addr_o),
        .xfer_load_o  (xfer_load_o),
        .xfer_reg_o   (xfer_reg_o),
        .xfer_word_o  (xfer_word_o),
        .done_o       (done_o),
        .wb_en_o      (wb_en_o),
        .wb_val_o     (wb_val_o),
        .illegal_o    (illegal_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit p, input bit u, input bit y, input bit wb,
                                       input bit l, input bit x, input logic [2:0] fd,
                                       input logic [3:0] cp, input logic [7:0] off);
        return {4'hE, 3'b110, p, u, y, wb, l, 4'h3, x, fd, cp, off};
    endfunction

    // Runs one legal instruction and checks the whole word stream (R2..R9)
    task automatic run_op(input logic [31:0] ins, input logic [31:0] base,
                          input bit stall, input bit inject);
        bit          p    = ins[24];
        bit          u    = ins[23];
        bit          wb   = ins[21];
        bit          l    = ins[20];
        int          nr   = ({ins[22], ins[15]} == 2'b00) ? 4 : int'({ins[22], ins[15]});
        int          nw   = 3 * nr;
        logic [31:0] mod  = u ? base + {22'd0, ins[7:0], 2'b00} : base - {22'd0, ins[7:0], 2'b00};
        logic [31:0] frst = p ? mod : base;
        int          k    = 0;
        int          cyc  = 0;
        @(negedge clk);
        instr_i = ins;
        base_i  = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (k < nw && cyc < 200) begin
            xfer_ready_i = stall ? (cyc % 3 != 1) : 1'b1;
            if (inject && cyc == 1) begin
                start_i = 1'b1;
                instr_i = 32'hE000_0000;
            end else begin
                start_i = 1'b0;
                instr_i = ins;
            end
            chk(xfer_valid_o == 1'b1, "R7 valid", 32'(xfer_valid_o), 32'd1);
            chk(xfer_addr_o == frst + 32'(4 * k), (k == 0) ? "R3 first addr" : "R4 addr",
                xfer_addr_o, frst + 32'(4 * k));
            chk(xfer_reg_o == 3'(int'(ins[14:12]) + k / 3), "R5 reg", 32'(xfer_reg_o),
                32'(3'(int'(ins[14:12]) + k / 3)));
            chk(xfer_word_o == 2'(k % 3), "R5 word", 32'(xfer_word_o), 32'(k % 3));
            chk(xfer_load_o == l, "R6 dir", 32'(xfer_load_o), 32'(l));
            chk(illegal_o == 1'b0 && accept_o == 1'b0, "R9 busy", 32'({illegal_o, accept_o}), 32'd0);
            if (xfer_ready_i) k++;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        xfer_ready_i = 1'b1;
        chk(done_o == 1'b1 && xfer_valid_o == 1'b0, "R2 count/R8 done", 32'({done_o, xfer_valid_o}), 32'd2);
        chk(wb_en_o == wb, "R8 wb_en", 32'(wb_en_o), 32'(wb));
        if (wb) chk(wb_val_o == mod, "R8 wb_val", wb_val_o, mod);
        @(negedge clk);
        chk(done_o == 1'b0 && accept_o == 1'b1 && illegal_o == 1'b0, "R8/R9 return idle",
            32'({done_o, accept_o, illegal_o}), 32'd2);
    endtask

    // Rejected encoding: one illegal pulse, nothing else (R1)
    task automatic run_bad(input logic [31:0] ins);
        @(negedge clk);
        instr_i = ins;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(illegal_o == 1'b1 && xfer_valid_o == 1'b0 && accept_o == 1'b0, "R1 illegal",
            32'({illegal_o, xfer_valid_o, accept_o}), 32'd4);
        @(negedge clk);
        chk(illegal_o == 1'b0 && xfer_valid_o == 1'b0 && done_o == 1'b0 && accept_o == 1'b1,
            "R1 after illegal", 32'({illegal_o, xfer_valid_o, done_o, accept_o}), 32'd1);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(accept_o == 1'b1 && xfer_valid_o == 1'b0 && done_o == 1'b0 && illegal_o == 1'b0,
            "R9 reset state", 32'({accept_o, xfer_valid_o, done_o, illegal_o}), 32'd8);
        // pre, up, write-back, one register, load
        run_op(mk(1, 1, 0, 1, 1, 1, 3'd2, 4'd2, 8'd5), 32'h0000_1000, 0, 0);
        // post, down, no write-back, four registers from 6 (wraps), store
        run_op(mk(0, 0, 0, 0, 0, 0, 3'd6, 4'd2, 8'd3), 32'h0000_2000, 0, 0);
        // pre, down, write-back, two registers, stalling ready
        run_op(mk(1, 0, 1, 1, 1, 0, 3'd0, 4'd2, 8'd16), 32'h0000_3000, 1, 0);
        // post, up, write-back, three registers, start injected while busy
        run_op(mk(0, 1, 1, 1, 0, 1, 3'd4, 4'd2, 8'd7), 32'h0000_4000, 1, 1);
        // widest offset going down, pre-indexed, wraps below zero
        run_op(mk(1, 0, 0, 1, 1, 1, 3'd7, 4'd2, 8'd255), 32'h0000_0100, 0, 0);
        // wrong opcode pattern, then wrong coprocessor number
        run_bad(32'hEE00_0205);
        run_bad(mk(1, 1, 0, 1, 1, 1, 3'd1, 4'd1, 8'd1));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule